// File: doc/BRIEF.md
# Delinquent Load Monitoring Table

This block watches retired load instructions and keeps per-load statistics over a monitoring period. Each retirement report carries the program counter of the load, its effective address, whether it missed in the data cache, and the miss latency. The table is 2-way set associative (1024 entries by default). The program counter selects a set, and the remaining upper bits are kept as a tag. An entry counts accesses, misses and summed miss latency, and it also keeps the last address seen and the signed address stride between the last two accesses.

A load is *delinquent* when it misses often and slowly. After the minimum access and miss counts are reached, the table tests the miss rate against a programmable power-of-two ratio. It also tests the average miss latency against a programmable limit. Both tests use no divider. When both tests pass, the table emits a one-cycle event that carries the load's PC, once per entry per period. A period-clear strobe invalidates every entry, so counting restarts. A lookup port returns an entry's fields one cycle after the request.

Top module: `dlt_monitor`

## Requirements
- R1: After reset, no event is signalled and every lookup reports a miss.
- R2: Each access to a tracked load increments its access count. A report with the miss flag set increments the miss count and adds the report's latency to the latency sum. The latency of a hit report is ignored.
- R3: Every access stores its address as the last address. The stride is the current address minus the previous stored address, modulo 2^ADDR_W (two's complement, so it may be negative). A newly allocated entry has stride 0.
- R4: No event is raised while the access count is below MIN_ACC (256) or the miss count is below MIN_MISS (8), even when both ratio tests pass.
- R5: The miss-rate test passes only when miss_count * 2^cfg_rate_shift_i is strictly greater than access_count.
- R6: The latency test passes only when latency_sum is strictly greater than cfg_lat_limit_i * miss_count.
- R7: The report that first satisfies R4–R6 for an entry yields evt_valid_o high for exactly one cycle, two clock edges after the report is sampled, with evt_pc_o equal to the load's PC. That entry raises no further event in the same period, and its sticky flag reads 1 on lookup.
- R8: A cycle with period_clr_i high invalidates all entries. A report whose update completes in that same cycle is discarded. Loads seen afterwards start from zero counts and can raise an event again.
- R9: The set index is PC bits [ALIGN_BITS +: log2(ENTRIES/2)], and the upper bits form the tag. Two loads that share a set are both tracked at once.
- R10: A new load fills an invalid way first (way 0 before way 1). When both ways are valid, it replaces the least recently accessed way of the set and starts that entry from fresh counts.
- R11: The access count, miss count and latency sum saturate at their all-ones value instead of wrapping.
- R12: A lookup sampled at one clock edge drives rd_valid_o high for the following cycle only. In that cycle it returns rd_hit_o and the stored flag, counts, last address and stride. All fields read zero on a miss.
- R13: Reports on back-to-back cycles to the same load are all counted. A lookup issued in the cycle that an update completes returns the updated entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate_shift_i | input | SHIFT_W | Miss-rate shift k (rate test: miss * 2^k > access) |
| cfg_lat_limit_i | input | LAT_W | Average miss latency limit |
| period_clr_i | input | 1 | Start of a new monitoring period |
| ld_valid_i | input | 1 | Load report valid |
| ld_pc_i | input | PC_W | Load program counter |
| ld_addr_i | input | ADDR_W | Load effective address |
| ld_miss_i | input | 1 | Load missed in the cache |
| ld_lat_i | input | LAT_W | Miss latency in cycles |
| evt_valid_o | output | 1 | Delinquent event pulse |
| evt_pc_o | output | PC_W | PC of the delinquent load |
| rd_req_i | input | 1 | Lookup request |
| rd_pc_i | input | PC_W | PC to look up |
| rd_valid_o | output | 1 | Lookup response valid |
| rd_hit_o | output | 1 | Lookup found the PC |
| rd_flag_o | output | 1 | Entry already reported this period |
| rd_acc_o | output | ACC_W | Access count |
| rd_miss_o | output | MISS_W | Miss count |
| rd_lsum_o | output | LSUM_W | Summed miss latency |
| rd_last_o | output | ADDR_W | Last address |
| rd_stride_o | output | ADDR_W | Last stride, two's complement |

## Verification
The bench drives several distinct miss patterns, and each one isolates a single evaluation gate. A half-miss stream at high latency shows the access minimum and the single-shot event. A mostly-hit stream with a large shift isolates the miss minimum. A quarter-miss stream sits exactly on the rate boundary, and a half-miss stream at exactly the latency limit sits on the latency boundary. In each of these, one extra report tips the result and shows that the comparison is strict. Address sequences that step forward and then back check the signed stride. Three PCs that alias to one set, with a reordered access pattern, separate LRU replacement from simple fill order. Long all-hit runs and back-to-back bursts, followed by an immediate lookup, expose counter wrap and stale read-modify-write data.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  typedef enum logic [1:0] {
    UPD_IDLE,
    UPD_HIT,
    UPD_FILL
  } upd_op_e;

  // choose the way to fill: an empty way first, otherwise the LRU way
  function automatic logic pick_victim(input logic v0, input logic v1, input logic lru);
    if (!v0)      return 1'b0;
    else if (!v1) return 1'b1;
    else          return lru;
  endfunction

endpackage

// File: rtl/dlt_way_ram.sv
module dlt_way_ram #(
  parameter int DEPTH = 512,
  parameter int AW    = 9,
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    a_addr,
  output logic [WIDTH-1:0] a_data,
  input  logic [AW-1:0]    b_addr,
  output logic [WIDTH-1:0] b_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // read-before-write on both read ports; the top bypasses same-edge writes
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_data <= mem[a_addr];
    b_data <= mem[b_addr];
  end

endmodule

// File: rtl/dlt_judge.sv
module dlt_judge #(
  parameter int ACC_W    = 16,
  parameter int MISS_W   = 16,
  parameter int LSUM_W   = 24,
  parameter int LAT_W    = 12,
  parameter int SHIFT_W  = 4,
  parameter int MIN_ACC  = 256,
  parameter int MIN_MISS = 8
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [MISS_W-1:0]  miss_i,
  input  logic [LSUM_W-1:0]  lsum_i,
  input  logic               flag_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [LAT_W-1:0]   limit_i,
  output logic               delinq_o
);

  localparam int SCL_W = MISS_W + (1 << SHIFT_W);
  localparam int PRD_W = LAT_W + MISS_W;
  localparam int CMP_W = (LSUM_W > PRD_W) ? LSUM_W : PRD_W;
  localparam logic [31:0] MIN_ACC_U  = MIN_ACC;
  localparam logic [31:0] MIN_MISS_U = MIN_MISS;

  logic [SCL_W-1:0] scaled;
  logic [PRD_W-1:0] budget;
  logic             cnt_ok, rate_ok, lat_ok;

  always_comb begin
    scaled   = SCL_W'(miss_i) << shift_i;
    budget   = PRD_W'(limit_i) * PRD_W'(miss_i);
    cnt_ok   = (32'(acc_i) >= MIN_ACC_U) && (32'(miss_i) >= MIN_MISS_U);
    rate_ok  = scaled > SCL_W'(acc_i);
    lat_ok   = CMP_W'(lsum_i) > CMP_W'(budget);
    delinq_o = cnt_ok && rate_ok && lat_ok && !flag_i;
  end

endmodule

// File: rtl/dlt_entry_update.sv
module dlt_entry_update
  import dlt_pkg::*;
#(
  parameter int TAG_W    = 21,
  parameter int ADDR_W   = 32,
  parameter int ACC_W    = 16,
  parameter int MISS_W   = 16,
  parameter int LSUM_W   = 24,
  parameter int LAT_W    = 12,
  parameter int SHIFT_W  = 4,
  parameter int MIN_ACC  = 256,
  parameter int MIN_MISS = 8,
  parameter int ENT_W    = 1 + TAG_W + 2*ADDR_W + ACC_W + MISS_W + LSUM_W
) (
  input  upd_op_e            op_i,
  input  logic [ENT_W-1:0]   cur_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               miss_i,
  input  logic [LAT_W-1:0]   lat_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [LAT_W-1:0]   limit_i,
  output logic [ENT_W-1:0]   nxt_o,
  output logic               fire_o
);

  typedef struct packed {
    logic              flag;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] last;
    logic [ADDR_W-1:0] stride;
    logic [ACC_W-1:0]  acc;
    logic [MISS_W-1:0] miss;
    logic [LSUM_W-1:0] lsum;
  } ent_t;

  ent_t              cur, pre, fin;
  logic [ACC_W:0]    acc_sum;
  logic [MISS_W:0]   miss_sum;
  logic [LSUM_W:0]   lsum_sum;
  logic [LSUM_W-1:0] add_lat;
  logic              delinq;

  always_comb begin
    cur      = ent_t'(cur_i);
    add_lat  = miss_i ? LSUM_W'(lat_i) : '0;
    acc_sum  = {1'b0, cur.acc} + (ACC_W+1)'(1);
    miss_sum = {1'b0, cur.miss} + (MISS_W+1)'(miss_i);
    lsum_sum = {1'b0, cur.lsum} + {1'b0, add_lat};
    pre      = cur;
    unique case (op_i)
      UPD_HIT: begin
        pre.acc    = acc_sum[ACC_W]   ? '1 : acc_sum[ACC_W-1:0];
        pre.miss   = miss_sum[MISS_W] ? '1 : miss_sum[MISS_W-1:0];
        pre.lsum   = lsum_sum[LSUM_W] ? '1 : lsum_sum[LSUM_W-1:0];
        pre.stride = addr_i - cur.last;
        pre.last   = addr_i;
      end
      UPD_FILL: begin
        pre.flag   = 1'b0;
        pre.tag    = tag_i;
        pre.last   = addr_i;
        pre.stride = '0;
        pre.acc    = ACC_W'(1);
        pre.miss   = MISS_W'(miss_i);
        pre.lsum   = add_lat;
      end
      default: pre = cur;
    endcase
  end

  dlt_judge #(
    .ACC_W(ACC_W), .MISS_W(MISS_W), .LSUM_W(LSUM_W), .LAT_W(LAT_W),
    .SHIFT_W(SHIFT_W), .MIN_ACC(MIN_ACC), .MIN_MISS(MIN_MISS)
  ) u_judge (
    .acc_i   (pre.acc),
    .miss_i  (pre.miss),
    .lsum_i  (pre.lsum),
    .flag_i  (pre.flag),
    .shift_i (shift_i),
    .limit_i (limit_i),
    .delinq_o(delinq)
  );

  always_comb begin
    fire_o   = (op_i != UPD_IDLE) && delinq;
    fin      = pre;
    fin.flag = pre.flag | fire_o;
    nxt_o    = fin;
  end

  // R11
  always_comb begin
    if (op_i == UPD_HIT) begin
      no_wrap_chk: assert (pre.acc >= cur.acc && pre.miss >= cur.miss && pre.lsum >= cur.lsum);
    end
  end

endmodule

// File: rtl/dlt_monitor.sv
module dlt_monitor
  import dlt_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 1024,
  parameter int ALIGN_BITS = 2,
  parameter int ACC_W      = 16,
  parameter int MISS_W     = 16,
  parameter int LAT_W      = 12,
  parameter int LSUM_W     = 24,
  parameter int SHIFT_W    = 4,
  parameter int MIN_ACC    = 256,
  parameter int MIN_MISS   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SHIFT_W-1:0] cfg_rate_shift_i,
  input  logic [LAT_W-1:0]   cfg_lat_limit_i,
  input  logic               period_clr_i,
  input  logic               ld_valid_i,
  input  logic [PC_W-1:0]    ld_pc_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic               ld_miss_i,
  input  logic [LAT_W-1:0]   ld_lat_i,
  output logic               evt_valid_o,
  output logic [PC_W-1:0]    evt_pc_o,
  input  logic               rd_req_i,
  input  logic [PC_W-1:0]    rd_pc_i,
  output logic               rd_valid_o,
  output logic               rd_hit_o,
  output logic               rd_flag_o,
  output logic [ACC_W-1:0]   rd_acc_o,
  output logic [MISS_W-1:0]  rd_miss_o,
  output logic [LSUM_W-1:0]  rd_lsum_o,
  output logic [ADDR_W-1:0]  rd_last_o,
  output logic [ADDR_W-1:0]  rd_stride_o
);

  // two ways with one LRU bit per set
  localparam int WAYS  = 2;
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = PC_W - IDX_W - ALIGN_BITS;
  localparam int ENT_W = 1 + TAG_W + 2*ADDR_W + ACC_W + MISS_W + LSUM_W;

  typedef struct packed {
    logic              flag;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] last;
    logic [ADDR_W-1:0] stride;
    logic [ACC_W-1:0]  acc;
    logic [MISS_W-1:0] miss;
    logic [LSUM_W-1:0] lsum;
  } ent_t;

  // stage 1 report registers
  logic              s1_valid;
  logic [PC_W-1:0]   s1_pc;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_miss;
  logic [LAT_W-1:0]  s1_lat;
  logic [IDX_W-1:0]  s1_set;
  logic [TAG_W-1:0]  s1_tag;

  // state flops
  logic [SETS-1:0]   valid_q [WAYS];
  logic [SETS-1:0]   lru_q;

  // write of the last edge, replayed to reads taken at that edge
  logic              byp_v;
  logic [IDX_W-1:0]  byp_set;
  logic              byp_way;
  logic [ENT_W-1:0]  byp_data;

  // lookup
  logic              rd_v_q;
  logic [PC_W-1:0]   rd_pc_q;
  logic [IDX_W-1:0]  rq_set;
  logic [TAG_W-1:0]  rq_tag;

  logic [ENT_W-1:0]  s1_raw [WAYS];
  logic [ENT_W-1:0]  rd_raw [WAYS];
  ent_t              s1_ent [WAYS];
  ent_t              rd_ent [WAYS];
  logic [WAYS-1:0]   s1_vld, s1_hitw, rd_vld, rd_hitw;

  logic              s1_hit, sel_way, wr_en, upd_fire;
  upd_op_e           upd_op;
  logic [ENT_W-1:0]  nxt_flat;
  ent_t              nxt_ent, rd_sel;

  assign s1_set = s1_pc[ALIGN_BITS +: IDX_W];
  assign s1_tag = s1_pc[PC_W-1 -: TAG_W];
  assign rq_set = rd_pc_q[ALIGN_BITS +: IDX_W];
  assign rq_tag = rd_pc_q[PC_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    dlt_way_ram #(.DEPTH(SETS), .AW(IDX_W), .WIDTH(ENT_W)) u_ram (
      .clk   (clk),
      .we    (wr_en && (sel_way == 1'(w))),
      .waddr (s1_set),
      .wdata (nxt_flat),
      .a_addr(ld_pc_i[ALIGN_BITS +: IDX_W]),
      .a_data(s1_raw[w]),
      .b_addr(rd_pc_i[ALIGN_BITS +: IDX_W]),
      .b_data(rd_raw[w])
    );

    assign s1_ent[w]  = ent_t'((byp_v && byp_set == s1_set && byp_way == 1'(w)) ? byp_data : s1_raw[w]);
    assign s1_vld[w]  = valid_q[w][s1_set];
    assign s1_hitw[w] = s1_vld[w] && (s1_ent[w].tag == s1_tag);

    assign rd_ent[w]  = ent_t'((byp_v && byp_set == rq_set && byp_way == 1'(w)) ? byp_data : rd_raw[w]);
    assign rd_vld[w]  = valid_q[w][rq_set];
    assign rd_hitw[w] = rd_vld[w] && (rd_ent[w].tag == rq_tag);
  end

  always_comb begin
    s1_hit  = |s1_hitw;
    sel_way = s1_hit ? s1_hitw[1] : pick_victim(s1_vld[0], s1_vld[1], lru_q[s1_set]);
    upd_op  = !s1_valid ? UPD_IDLE : (s1_hit ? UPD_HIT : UPD_FILL);
    wr_en   = s1_valid && !period_clr_i;
  end

  dlt_entry_update #(
    .TAG_W(TAG_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W), .MISS_W(MISS_W),
    .LSUM_W(LSUM_W), .LAT_W(LAT_W), .SHIFT_W(SHIFT_W),
    .MIN_ACC(MIN_ACC), .MIN_MISS(MIN_MISS), .ENT_W(ENT_W)
  ) u_update (
    .op_i   (upd_op),
    .cur_i  (s1_ent[sel_way]),
    .tag_i  (s1_tag),
    .addr_i (s1_addr),
    .miss_i (s1_miss),
    .lat_i  (s1_lat),
    .shift_i(cfg_rate_shift_i),
    .limit_i(cfg_lat_limit_i),
    .nxt_o  (nxt_flat),
    .fire_o (upd_fire)
  );

  assign nxt_ent = ent_t'(nxt_flat);

  // control flops
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid    <= 1'b0;
      rd_v_q      <= 1'b0;
      byp_v       <= 1'b0;
      evt_valid_o <= 1'b0;
      lru_q       <= '0;
      for (int i = 0; i < WAYS; i++) valid_q[i] <= '0;
    end else begin
      s1_valid    <= ld_valid_i;
      rd_v_q      <= rd_req_i;
      byp_v       <= wr_en;
      evt_valid_o <= wr_en && upd_fire;
      if (period_clr_i) begin
        for (int i = 0; i < WAYS; i++) valid_q[i] <= '0;
      end else if (wr_en) begin
        valid_q[sel_way][s1_set] <= 1'b1;
      end
      if (wr_en) lru_q[s1_set] <= ~sel_way;
    end
  end

  // data flops
  always_ff @(posedge clk) begin
    s1_pc    <= ld_pc_i;
    s1_addr  <= ld_addr_i;
    s1_miss  <= ld_miss_i;
    s1_lat   <= ld_lat_i;
    rd_pc_q  <= rd_pc_i;
    byp_set  <= s1_set;
    byp_way  <= sel_way;
    byp_data <= nxt_flat;
    evt_pc_o <= s1_pc;
  end

  always_comb begin
    rd_sel      = (rd_v_q && |rd_hitw) ? rd_ent[rd_hitw[1]] : '0;
    rd_valid_o  = rd_v_q;
    rd_hit_o    = rd_v_q && |rd_hitw;
    rd_flag_o   = rd_sel.flag;
    rd_acc_o    = rd_sel.acc;
    rd_miss_o   = rd_sel.miss;
    rd_lsum_o   = rd_sel.lsum;
    rd_last_o   = rd_sel.last;
    rd_stride_o = rd_sel.stride;
  end

  // R9
  one_way_chk: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> $onehot0(s1_hitw));

  // R8
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    period_clr_i |=> (valid_q[0] == '0 && valid_q[1] == '0));

  // R7
  once_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && upd_fire) |-> !(s1_hit && s1_ent[s1_hitw[1]].flag));

  // R4
  min_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && upd_fire) |-> (32'(nxt_ent.acc) >= 32'(MIN_ACC) && 32'(nxt_ent.miss) >= 32'(MIN_MISS)));

endmodule

// File: tb/test_dlt_monitor.sv
`timescale 1ns/1ps
module test_dlt_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  k = 4'd2;
  logic [9:0]  limit = 10'd100;
  logic        period_clr = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0, ld_addr = '0;
  logic        ld_miss = 1'b0;
  logic [9:0]  ld_lat = '0;
  logic        evt_valid;
  logic [31:0] evt_pc;
  logic        rd_req = 1'b0;
  logic [31:0] rd_pc = '0;
  logic        rd_valid, rd_hit, rd_flag;
  logic [9:0]  rd_acc, rd_miss;
  logic [15:0] rd_lsum;
  logic [31:0] rd_last, rd_stride;

  int checks = 0, errors = 0, evt_cnt = 0, exp_evt = 0;

  always #4 clk = ~clk;

  dlt_monitor #(
    .ACC_W(10), .MISS_W(10), .LAT_W(10), .LSUM_W(16)
  ) i_dlt_monitor (
    .clk(clk), .rst(rst), .cfg_rate_shift_i(k), .cfg_lat_limit_i(limit),
    .period_clr_i(period_clr), .ld_valid_i(ld_valid), .ld_pc_i(ld_pc),
    .ld_addr_i(ld_addr), .ld_miss_i(ld_miss), .ld_lat_i(ld_lat),
    .evt_valid_o(evt_valid), .evt_pc_o(evt_pc), .rd_req_i(rd_req), .rd_pc_i(rd_pc),
    .rd_valid_o(rd_valid), .rd_hit_o(rd_hit), .rd_flag_o(rd_flag), .rd_acc_o(rd_acc),
    .rd_miss_o(rd_miss), .rd_lsum_o(rd_lsum), .rd_last_o(rd_last), .rd_stride_o(rd_stride)
  );

  always @(negedge clk) if (!rst && evt_valid) evt_cnt++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] pc, input logic [31:0] addr, input logic m, input logic [9:0] lat);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = addr; ld_miss = m; ld_lat = lat;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    ld_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pattern(input logic [31:0] pc, input int n, input int per, input logic [9:0] lat);
    for (int i = 1; i <= n; i++) send(pc, 32'h4000 + 32'(i) * 8, (i % per) == 0, lat);
  endtask

  task automatic lookup(input logic [31:0] pc);
    rd_req = 1'b1; rd_pc = pc;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 no event after reset", evt_valid, 0);
    lookup(32'h100);
    chk("R1 lookup miss after reset", rd_hit, 0);
  endtask

  task automatic t_stats_stride;
    send(32'h500, 32'h1000, 1'b0, 10'd999);
    idle(2);
    lookup(32'h500);
    chk("R2 hit on new entry", rd_hit, 1);
    chk("R2 hit latency ignored", rd_lsum, 0);
    chk("R3 fresh stride zero", rd_stride, 0);
    send(32'h500, 32'h1010, 1'b1, 10'd50);
    send(32'h500, 32'h1008, 1'b1, 10'd70);
    idle(2);
    lookup(32'h500);
    chk("R2 access count", rd_acc, 3);
    chk("R2 miss count", rd_miss, 2);
    chk("R2 latency sum", rd_lsum, 120);
    chk("R3 last address", rd_last, 32'h1008);
    chk("R3 negative stride", rd_stride, 32'hFFFF_FFF8);
  endtask

  task automatic t_readport;
    lookup(32'h0ABC_0000);
    chk("R12 response valid", rd_valid, 1);
    chk("R12 absent pc misses", rd_hit, 0);
    chk("R12 zero fields on miss", rd_acc, 0);
    @(negedge clk);
    chk("R12 single-cycle response", rd_valid, 0);
  endtask

  task automatic t_first_event;
    pattern(32'h100, 255, 2, 10'd200);
    idle(3);
    chk("R4 no event below access minimum", evt_cnt, exp_evt);
    send(32'h100, 32'h9000, 1'b1, 10'd200);
    chk("R7 event not yet", evt_valid, 0);
    ld_valid = 1'b0;
    @(negedge clk);
    chk("R7 event pulse", evt_valid, 1);
    chk("R7 event pc", evt_pc, 32'h100);
    @(negedge clk);
    chk("R7 pulse one cycle", evt_valid, 0);
    exp_evt++;
    pattern(32'h100, 20, 1, 10'd200);
    idle(3);
    chk("R7 once per period", evt_cnt, exp_evt);
    lookup(32'h100);
    chk("R7 sticky flag", rd_flag, 1);
    chk("R2 count after event", rd_miss, 148);
  endtask

  task automatic t_period;
    period_clr = 1'b1;
    @(negedge clk);
    period_clr = 1'b0;
    idle(2);
    lookup(32'h100);
    chk("R8 entry cleared", rd_hit, 0);
    lookup(32'h500);
    chk("R8 other entry cleared", rd_hit, 0);
    pattern(32'h100, 256, 2, 10'd200);
    idle(3);
    exp_evt++;
    chk("R8 event again in new period", evt_cnt, exp_evt);
  endtask

  task automatic t_min_miss;
    k = 4'd8;
    pattern(32'h200, 250, 100000, 10'd200);
    pattern(32'h200, 7, 1, 10'd200);
    idle(3);
    chk("R4 no event below miss minimum", evt_cnt, exp_evt);
    send(32'h200, 32'h7000, 1'b1, 10'd200);
    idle(3);
    exp_evt++;
    chk("R4 event at miss minimum", evt_cnt, exp_evt);
    k = 4'd2;
  endtask

  task automatic t_rate;
    pattern(32'h300, 256, 4, 10'd200);
    idle(3);
    chk("R5 equal rate no event", evt_cnt, exp_evt);
    send(32'h300, 32'h7000, 1'b1, 10'd200);
    idle(3);
    exp_evt++;
    chk("R5 rate above threshold", evt_cnt, exp_evt);
  endtask

  task automatic t_latency;
    pattern(32'h400, 256, 2, 10'd100);
    idle(3);
    chk("R6 equal latency no event", evt_cnt, exp_evt);
    send(32'h400, 32'h7000, 1'b1, 10'd101);
    idle(3);
    exp_evt++;
    chk("R6 latency above limit", evt_cnt, exp_evt);
  endtask

  task automatic t_sets;
    send(32'h800, 32'h10, 1'b0, 0);
    send(32'h1000, 32'h20, 1'b0, 0);
    idle(2);
    lookup(32'h800);
    chk("R9 first alias present", rd_hit, 1);
    lookup(32'h1000);
    chk("R9 second alias present", rd_hit, 1);
    send(32'h800, 32'h30, 1'b0, 0);
    send(32'h1800, 32'h40, 1'b0, 0);
    idle(2);
    lookup(32'h1000);
    chk("R10 LRU way evicted", rd_hit, 0);
    lookup(32'h800);
    chk("R10 recent way kept", rd_acc, 2);
    lookup(32'h1800);
    chk("R10 new entry fresh", rd_acc, 1);
  endtask

  task automatic t_saturate;
    pattern(32'h600, 1100, 100000, 0);
    idle(2);
    lookup(32'h600);
    chk("R11 access count saturates", rd_acc, 10'h3FF);
  endtask

  task automatic t_burst;
    for (int i = 0; i < 5; i++) send(32'h700, 32'h100 + 32'(i) * 4, 1'b1, 10'd3);
    ld_valid = 1'b0;
    lookup(32'h700);
    chk("R13 back-to-back counted", rd_acc, 5);
    chk("R13 back-to-back latency", rd_lsum, 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stats_stride();
    t_readport();
    t_first_event();
    t_period();
    t_min_miss();
    t_rate();
    t_latency();
    t_sets();
    t_saturate();
    t_burst();
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule